// File: doc/BRIEF.md
# Low-Transition Test Pattern Generator with Inserted Vectors

This block feeds pseudo-random test patterns to a circuit under test while limiting how many input bits toggle from one clock to the next. An internal linear feedback shift register steps only once every `M` system clocks. In the `M-1` cycles between two of its states, the block drives intermediate vectors that walk from the old state towards the new one a group of bits at a time. Every LFSR state still reaches the output.

The walk is driven by a compare vector, the bitwise XOR of the present LFSR state and its one-step successor. Bit positions fall into `M` groups by index modulo `M`. At each inserted step, one more group of differing bits takes its value from the new state. Applying fewer changes per clock lowers the switching activity in the circuit under test. The test set is unchanged, apart from the vectors placed between the patterns.

The generator runs while `run_i` is high. While it is low, the block freezes and marks its output as not valid.

Top module: `lowtrans_tpg`

## Requirements
- R1: After reset, `vec_o` equals `SEED`, `valid_o` and `full_o` are 0, and `cmp_o` equals `SEED` XOR next(`SEED`).
- R2: The LFSR successor function next(x) shifts x left by one and fills bit 0 with the XOR of the bits of x selected by `TAPS`.
- R3: Counting only cycles with `valid_o` high, `full_o` is high on every `M`-th output and on no other, so exactly `M-1` inserted vectors lie between two full patterns.
- R4: The vectors flagged by `full_o` follow the successor function: the first is next(`SEED`), and each later one is next of the one before.
- R5: `cmp_o` equals S XOR next(S), where S is the state the LFSR holds at that moment. S is `SEED` until the first full pattern and the last full pattern after that. `cmp_o` changes only in a cycle where `full_o` is high.
- R6: The j-th inserted vector after state S, with j from 1 to `M-1`, equals S XOR (`cmp_o` AND G(j)). G(j) has a 1 at every bit index i with i mod `M` < j.
- R7: Two consecutive valid outputs differ in at most ceil(`WIDTH`/`M`) bit positions. This includes the first valid output after reset compared with `SEED`.
- R8: In a cycle after `run_i` was sampled low, `valid_o` is 0 and `vec_o` keeps its value. When `run_i` returns high, the sequence continues from the step at which it stopped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| run_i | input | 1 | Advance the pattern sequence by one step on this clock |
| vec_o | output | WIDTH | Test vector applied to the circuit under test |
| valid_o | output | 1 | `vec_o` was updated on the last clock |
| full_o | output | 1 | `vec_o` holds a complete LFSR state rather than an inserted vector |
| cmp_o | output | WIDTH | Difference mask between the present LFSR state and its successor |

## Verification
The checker's properties assume that `run_i` is a clean synchronous level and that reset is applied before the first clock. With that assumption, the properties count valid outputs and compare each one with the previous valid output. The bench changes `run_i` only on falling edges. It mixes long running stretches with idle gaps of several lengths, and those gaps fall at different points in the `M`-step walk, so that freezing and resuming are exercised both between inserted vectors and right at a full pattern.

// File: rtl/lowtrans_tpg_pkg.sv
package lowtrans_tpg_pkg;
  function automatic int ceil_div(input int a, input int b);
    return (a + b - 1) / b;
  endfunction
endpackage

// File: rtl/lowtrans_tpg_phase.sv
module lowtrans_tpg_phase #(
  parameter int M    = 4,
  localparam int PH_W = $clog2(M)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            run_i,
  output logic [PH_W-1:0] phase_o,
  output logic            wrap_o
);
  localparam logic [PH_W-1:0] LAST = PH_W'(M - 1);

  logic [PH_W-1:0] phase_q;

  assign wrap_o  = (phase_q == LAST);
  assign phase_o = phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     phase_q <= '0;
    else if (run_i)  phase_q <= wrap_o ? '0 : phase_q + 1'b1;
  end
endmodule

// File: rtl/lowtrans_tpg_lfsr.sv
module lowtrans_tpg_lfsr #(
  parameter int               WIDTH = 8,
  parameter logic [WIDTH-1:0] TAPS  = 8'hB8,
  parameter logic [WIDTH-1:0] SEED  = 8'h01
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  output logic [WIDTH-1:0] state_o,
  output logic [WIDTH-1:0] next_o
);
  logic [WIDTH-1:0] state_q;

  // one-step lookahead of the feedback
  assign next_o  = {state_q[WIDTH-2:0], ^(state_q & TAPS)};
  assign state_o = state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    state_q <= SEED;
    else if (adv_i) state_q <= next_o;
  end
endmodule

// File: rtl/lowtrans_tpg_mix.sv
module lowtrans_tpg_mix #(
  parameter int WIDTH = 8,
  parameter int M     = 4,
  localparam int PH_W = $clog2(M)
) (
  input  logic [PH_W-1:0]  phase_i,
  input  logic [WIDTH-1:0] old_i,
  input  logic [WIDTH-1:0] cmp_i,
  output logic [WIDTH-1:0] vec_o
);
  logic [WIDTH-1:0] sel;

  // bit i switches once its group (i mod M) is within groups 0..phase
  for (genvar i = 0; i < WIDTH; i++) begin : g_sel
    localparam int G = i % M;
    assign sel[i] = (PH_W'(G) <= phase_i);
  end

  assign vec_o = old_i ^ (cmp_i & sel);
endmodule

// File: rtl/lowtrans_tpg.sv
module lowtrans_tpg #(
  parameter int               WIDTH = 8,
  parameter int               M     = 4,
  parameter logic [WIDTH-1:0] TAPS  = 8'hB8,
  parameter logic [WIDTH-1:0] SEED  = 8'h01
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  output logic [WIDTH-1:0] vec_o,
  output logic             valid_o,
  output logic             full_o,
  output logic [WIDTH-1:0] cmp_o
);
  localparam int PH_W = $clog2(M);

  logic [PH_W-1:0]  phase;
  logic             wrap;
  logic [WIDTH-1:0] state, next, cmp, mixed;
  logic [WIDTH-1:0] vec_q;
  logic             valid_q, full_q;

  lowtrans_tpg_phase #(.M(M)) u_phase (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (run_i),
    .phase_o (phase),
    .wrap_o  (wrap)
  );

  lowtrans_tpg_lfsr #(.WIDTH(WIDTH), .TAPS(TAPS), .SEED(SEED)) u_lfsr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .adv_i   (run_i & wrap),
    .state_o (state),
    .next_o  (next)
  );

  assign cmp = state ^ next;

  lowtrans_tpg_mix #(.WIDTH(WIDTH), .M(M)) u_mix (
    .phase_i (phase),
    .old_i   (state),
    .cmp_i   (cmp),
    .vec_o   (mixed)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vec_q   <= SEED;
      valid_q <= 1'b0;
      full_q  <= 1'b0;
    end else begin
      valid_q <= run_i;
      full_q  <= run_i & wrap;
      if (run_i) vec_q <= mixed;
    end
  end

  assign vec_o   = vec_q;
  assign valid_o = valid_q;
  assign full_o  = full_q;
  assign cmp_o   = cmp;
endmodule

// File: rtl/lowtrans_tpg_chk.sv
module lowtrans_tpg_chk #(
  parameter int               WIDTH = 8,
  parameter int               M     = 4,
  parameter logic [WIDTH-1:0] SEED  = 8'h01
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             run_i,
  input logic [WIDTH-1:0] vec_o,
  input logic             valid_o,
  input logic             full_o,
  input logic [WIDTH-1:0] cmp_o
);
  localparam int STEP_MAX = lowtrans_tpg_pkg::ceil_div(WIDTH, M);
  localparam int CNT_W    = $clog2(M) + 1;

  logic [CNT_W-1:0] since_full_q;
  logic [WIDTH-1:0] last_vec_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      since_full_q <= '0;
      last_vec_q   <= SEED;
    end else if (valid_o) begin
      since_full_q <= full_o ? '0 : since_full_q + 1'b1;
      last_vec_q   <= vec_o;
    end
  end

  // R3
  full_spacing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && full_o) |-> (since_full_q == CNT_W'(M - 1)));

  // R3
  inserted_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !full_o) |-> (since_full_q < CNT_W'(M - 1)));

  // R7
  low_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ($countones(vec_o ^ last_vec_q) <= STEP_MAX));

  // R8
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (!valid_o && $stable(vec_o)));

  // R5
  cmp_steady_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !full_o |-> $stable(cmp_o));
endmodule

bind lowtrans_tpg lowtrans_tpg_chk #(.WIDTH(WIDTH), .M(M), .SEED(SEED)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .run_i   (run_i),
  .vec_o   (vec_o),
  .valid_o (valid_o),
  .full_o  (full_o),
  .cmp_o   (cmp_o)
);

// File: tb/tb_lowtrans_tpg.sv
module tb_lowtrans_tpg;
  localparam int               W    = 8;
  localparam int               M    = 4;
  localparam logic [W-1:0]     TAPS = 8'hB8;
  localparam logic [W-1:0]     SEED = 8'h01;
  localparam int               STEP_MAX = (W + M - 1) / M;

  typedef struct packed {
    logic [W-1:0] vec;
    logic         full;
    logic [W-1:0] cmp;
  } item_t;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         run_i = 1'b0;
  logic [W-1:0] vec_o, cmp_o;
  logic         valid_o, full_o;

  int checks = 0;
  int fails  = 0;
  bit live   = 1'b0;
  bit done   = 1'b0;

  item_t        exp_q[$];
  logic [W-1:0] m_cur = SEED;
  int           m_phase = 0;
  logic [W-1:0] last_vec = SEED;

  always #4 clk_i = ~clk_i;

  lowtrans_tpg #(.WIDTH(W), .M(M), .TAPS(TAPS), .SEED(SEED)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run_i),
    .vec_o(vec_o), .valid_o(valid_o), .full_o(full_o), .cmp_o(cmp_o)
  );

  // R2 successor function, built from the requirement
  function automatic logic [W-1:0] nxt(input logic [W-1:0] x);
    return {x[W-2:0], ^(x & TAPS)};
  endfunction

  function automatic logic [W-1:0] grp(input int j);
    logic [W-1:0] g = '0;
    for (int i = 0; i < W; i++) g[i] = ((i % M) < j);
    return g;
  endfunction

  task automatic check(input bit ok, input string req, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // driver: one cycle of stimulus; push the expected result when running
  task automatic drive(input bit run);
    item_t it;
    @(negedge clk_i);
    run_i = run;
    if (run) begin
      it.vec  = m_cur ^ ((m_cur ^ nxt(m_cur)) & grp(m_phase + 1));
      it.full = (m_phase == M - 1);
      if (it.full) begin
        m_cur   = nxt(m_cur);
        m_phase = 0;
      end else m_phase++;
      it.cmp = m_cur ^ nxt(m_cur);
      exp_q.push_back(it);
    end
  endtask

  // monitor: outputs from the last rising edge, sampled at the falling edge
  always @(negedge clk_i) begin
    item_t e;
    if (live && !done) begin
      if (valid_o) begin
        if (exp_q.size() == 0) check(1'b0, "R8 unexpected valid", vec_o, '0);
        else begin
          e = exp_q.pop_front();
          if (e.full) check(vec_o === e.vec, "R4 full pattern", vec_o, e.vec);
          else        check(vec_o === e.vec, "R6 inserted vector", vec_o, e.vec);
          check(full_o === e.full, "R3 full flag", W'(full_o), W'(e.full));
          check(cmp_o === e.cmp, "R5 compare vector", cmp_o, e.cmp);
          check($countones(vec_o ^ last_vec) <= STEP_MAX, "R7 toggle bound",
                W'($countones(vec_o ^ last_vec)), W'(STEP_MAX));
        end
        last_vec = vec_o;
      end else begin
        check(vec_o === last_vec, "R8 hold while idle", vec_o, last_vec);
        check(full_o === 1'b0, "R8 no full while idle", W'(full_o), '0);
      end
    end
  end

  initial begin
    #400_000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    check(vec_o === SEED, "R1 vec", vec_o, SEED);
    check(W'(valid_o) === '0, "R1 valid", W'(valid_o), '0);
    check(W'(full_o) === '0, "R1 full", W'(full_o), '0);
    check(cmp_o === (SEED ^ nxt(SEED)), "R1 cmp", cmp_o, SEED ^ nxt(SEED));
    rst_ni = 1'b1;
    live = 1'b1;
    // long continuous run
    for (int k = 0; k < 40 * M; k++) drive(1'b1);
    // idle gaps landing at every phase of the walk
    for (int g = 0; g < 2 * M; g++) begin
      for (int k = 0; k < g + 1; k++) drive(1'b1);
      for (int k = 0; k < (g % 3) + 1; k++) drive(1'b0);
    end
    // alternating run/idle
    for (int k = 0; k < 6 * M; k++) drive(k[0]);
    for (int k = 0; k < 3 * M; k++) drive(1'b1);
    drive(1'b0);
    drive(1'b0);
    @(negedge clk_i);
    check(W'(exp_q.size()) === '0, "R3 all outputs seen", W'(exp_q.size()), '0);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule